// File: doc/BRIEF.md
# Paged Address Translation Unit

This block converts a logical byte address into a physical byte address using fixed-size pages. The low bits of the address are the offset within a page and pass through unchanged. The upper bits are the page number, which is replaced by a frame number. A small fully associative translation cache is searched first. If the page is not cached, the unit reads one page-table entry through a simple memory request/response port. It then checks the entry's present bit and, only if that passes, its access permissions.

One translation is in flight at a time. The requester raises `req_valid` with the address, the access direction (read or write) and the privilege (user or supervisor). The unit answers with a registered response. The response holds the physical address and a status code: success, page fault or protection fault. The page table is a linear array of 32-bit entries that starts at `pt_base`. A `flush` input empties the translation cache, for use after the table has been changed.

Top module: `paged_xlate_unit`

## Requirements
- R1: With 4 KB pages, the low 12 bits of the logical address are the offset and the rest is the page number. A successful response returns `{frame, offset}` with the offset unchanged. For example, page 7 in frame 42 maps 0x00007B00 to 0x0002AB00.
- R2: On a cache hit, `rsp_valid` rises in the cycle after the request is accepted and no memory request is made. The permission check on a hit uses the permissions stored in the cache entry.
- R3: On a miss, exactly one memory read is issued, at address `pt_base + 4*page`. The response becomes valid in the cycle after `mem_rsp_valid`.
- R4: A page-table entry is 32 bits wide. Bit 0 is present, bit 1 is writable, bit 2 is user-accessible, and bits [31:12] hold the frame number.
- R5: If the entry's present bit is clear, the response status is 2'b01 (page fault) and the address is zero. Such an entry is not cached, so a repeated access walks the table again.
- R6: A write to a page that is not writable, or a user access to a page without the user bit, returns status 2'b10 (protection fault) with a zero address. A page fault takes precedence over a protection fault. A successful access returns status 2'b00.
- R7: The cache holds 8 entries and replaces them round robin. Every present entry that is read from the table is cached, including one that ends in a protection fault. The ninth distinct fill evicts the oldest entry.
- R8: `flush` removes every cached entry. A request accepted in a cycle where `flush` is high is treated as a miss.
- R9: `req_ready` is high only while no translation is in progress. The response stays valid and stable until `rsp_ready`. A memory request stays valid and stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the translation cache |
| pt_base | input | 32 | Byte address of page-table entry 0 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Logical address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-privilege access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| mem_req_valid | output | 1 | Page-table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry read |

## Verification
The hardest state to reach from the ports is a full cache with a known oldest entry, followed by an eviction. Reaching it takes a flush and then eight distinct present pages in a known order. The stimulus then confirms that the first page still hits, fills a ninth page, and shows that a later page still hits while the first page walks again. A second hard case is a request that arrives in the same cycle as a flush for a page that is cached. The bench drives both inputs at the same clock edge and expects a table read.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [1:0] {
      XST_OK         = 2'b00,
      XST_PAGE_FAULT = 2'b01,
      XST_PROT_FAULT = 2'b10
   } xlate_status_e;

   typedef enum logic [1:0] {
      FSM_IDLE,
      FSM_PT_REQ,
      FSM_PT_WAIT,
      FSM_RESP
   } xlate_fsm_e;

   // permission vector carried in the cache
   localparam int PERM_W   = 2;
   localparam int PERM_WR  = 0;
   localparam int PERM_USR = 1;

   // page-table entry flag positions
   localparam int PTE_V_BIT = 0;
   localparam int PTE_W_BIT = 1;
   localparam int PTE_U_BIT = 2;

endpackage

// File: rtl/xlate_pte_unpack.sv
module xlate_pte_unpack
   import xlate_pkg::*;
#(
   parameter int PTE_W = 32,
   parameter int OFS_W = 12,
   parameter int PFN_W = 20
) (
   input  logic [PTE_W-1:0]  pte,
   output logic              present,
   output logic [PERM_W-1:0] perm,
   output logic [PFN_W-1:0]  pfn
);

   initial begin : elab_chk
      assert (PTE_W == OFS_W + PFN_W)
         else $error("entry width must equal offset plus frame width");
      assert (OFS_W > PTE_U_BIT + 1)
         else $error("offset too narrow for entry flags");
   end

   assign present        = pte[PTE_V_BIT];
   assign perm[PERM_WR]  = pte[PTE_W_BIT];
   assign perm[PERM_USR] = pte[PTE_U_BIT];
   assign pfn            = pte[OFS_W +: PFN_W];

   wire unused_pte_bits = ^pte[OFS_W-1:PTE_U_BIT+1];

endmodule

// File: rtl/xlate_access_gate.sv
module xlate_access_gate
   import xlate_pkg::*;
(
   input  logic              is_write,
   input  logic              is_user,
   input  logic [PERM_W-1:0] perm,
   output logic              deny
);

   logic wr_block;
   logic usr_block;

   always_comb begin
      wr_block  = is_write && !perm[PERM_WR];
      usr_block = is_user  && !perm[PERM_USR];
      deny      = wr_block || usr_block;
   end

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
   import xlate_pkg::*;
#(
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam bit POW2  = (ENTRIES & (ENTRIES - 1)) == 0;

   initial begin : elab_chk
      assert (ENTRIES >= 2) else $error("cache needs at least two entries");
      assert (VPN_W >= 1 && PFN_W >= 1) else $error("bad tag widths");
   end

   logic [ENTRIES-1:0] ent_vld;
   logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
   logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
   logic [PERM_W-1:0]  ent_perm [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [IDX_W-1:0]   ptr_q;
   logic [IDX_W-1:0]   ptr_next;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = ent_vld[g] && (ent_vpn[g] == lk_vpn);
   end

   // replacement pointer wrap: free for powers of two, compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign ptr_next = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_next = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_comb begin
      lk_hit  = |match;
      lk_pfn  = '0;
      lk_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         lk_pfn  = lk_pfn  | ({PFN_W{match[i]}}  & ent_pfn[i]);
         lk_perm = lk_perm | ({PERM_W{match[i]}} & ent_perm[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld <= '0;
         ptr_q   <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            ent_vpn[i]  <= '0;
            ent_pfn[i]  <= '0;
            ent_perm[i] <= '0;
         end
      end else if (flush) begin
         ent_vld <= '0;
      end else if (fill_en) begin
         ent_vld[ptr_q]  <= 1'b1;
         ent_vpn[ptr_q]  <= fill_vpn;
         ent_pfn[ptr_q]  <= fill_pfn;
         ent_perm[ptr_q] <= fill_perm;
         ptr_q           <= ptr_next;
      end
   end

   AST_TLB_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R7
   AST_TLB_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit); // R8

endmodule

// File: rtl/paged_xlate_unit.sv
module paged_xlate_unit
   import xlate_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_BYTES  = 4096,
   parameter int PTE_BYTES   = 4,
   parameter int TLB_ENTRIES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic [PA_W-1:0]        pt_base,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic                   req_write,
   input  logic                   req_user,
   output logic                   rsp_valid,
   input  logic                   rsp_ready,
   output logic [PA_W-1:0]        rsp_paddr,
   output logic [1:0]             rsp_status,
   output logic                   mem_req_valid,
   input  logic                   mem_req_ready,
   output logic [PA_W-1:0]        mem_req_addr,
   input  logic                   mem_rsp_valid,
   input  logic [PTE_BYTES*8-1:0] mem_rsp_data
);

   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int VPN_W  = VA_W - OFS_W;
   localparam int PFN_W  = PA_W - OFS_W;
   localparam int PTE_W  = PTE_BYTES * 8;
   localparam int PTE_SH = $clog2(PTE_BYTES);

   initial begin : elab_chk
      assert ((PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("page size must be a power of two");
      assert ((PTE_BYTES & (PTE_BYTES - 1)) == 0)
         else $error("entry size must be a power of two");
      assert (VA_W > OFS_W && PA_W > OFS_W)
         else $error("address narrower than page offset");
      assert (PA_W >= VPN_W + PTE_SH)
         else $error("table index does not fit the physical address");
   end

   xlate_fsm_e        state_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              wr_q;
   logic              usr_q;
   logic [PA_W-1:0]   pt_addr_q;
   logic [PA_W-1:0]   paddr_q;
   xlate_status_e     status_q;

   logic [VPN_W-1:0]  req_vpn;
   logic [OFS_W-1:0]  req_ofs;
   logic              accept;
   logic              lk_hit;
   logic              hit_use;
   logic [PFN_W-1:0]  lk_pfn;
   logic [PERM_W-1:0] lk_perm;
   logic              hit_deny;
   logic              pte_present;
   logic [PERM_W-1:0] pte_perm;
   logic [PFN_W-1:0]  pte_pfn;
   logic              walk_deny;
   logic              fill_en;

   assign req_vpn   = req_vaddr[VA_W-1:OFS_W];
   assign req_ofs   = req_vaddr[OFS_W-1:0];
   assign req_ready = (state_q == FSM_IDLE);
   assign accept    = req_valid && req_ready;
   assign hit_use   = lk_hit && !flush;
   assign fill_en   = (state_q == FSM_PT_WAIT) && mem_rsp_valid && pte_present;

   assign rsp_valid     = (state_q == FSM_RESP);
   assign rsp_paddr     = paddr_q;
   assign rsp_status    = status_q;
   assign mem_req_valid = (state_q == FSM_PT_REQ);
   assign mem_req_addr  = pt_addr_q;

   xlate_tlb #(
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .ENTRIES (TLB_ENTRIES)
   ) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .lk_vpn    (req_vpn),
      .lk_hit    (lk_hit),
      .lk_pfn    (lk_pfn),
      .lk_perm   (lk_perm),
      .fill_en   (fill_en),
      .fill_vpn  (vpn_q),
      .fill_pfn  (pte_pfn),
      .fill_perm (pte_perm)
   );

   xlate_pte_unpack #(
      .PTE_W (PTE_W),
      .OFS_W (OFS_W),
      .PFN_W (PFN_W)
   ) u_unpack (
      .pte     (mem_rsp_data),
      .present (pte_present),
      .perm    (pte_perm),
      .pfn     (pte_pfn)
   );

   xlate_access_gate u_gate_hit (
      .is_write (req_write),
      .is_user  (req_user),
      .perm     (lk_perm),
      .deny     (hit_deny)
   );

   xlate_access_gate u_gate_walk (
      .is_write (wr_q),
      .is_user  (usr_q),
      .perm     (pte_perm),
      .deny     (walk_deny)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= FSM_IDLE;
         vpn_q     <= '0;
         ofs_q     <= '0;
         wr_q      <= 1'b0;
         usr_q     <= 1'b0;
         pt_addr_q <= '0;
         paddr_q   <= '0;
         status_q  <= XST_OK;
      end else begin
         case (state_q)
            FSM_IDLE: begin
               if (accept) begin
                  vpn_q     <= req_vpn;
                  ofs_q     <= req_ofs;
                  wr_q      <= req_write;
                  usr_q     <= req_user;
                  pt_addr_q <= pt_base + (PA_W'(req_vpn) << PTE_SH);
                  if (hit_use) begin
                     state_q <= FSM_RESP;
                     if (hit_deny) begin
                        status_q <= XST_PROT_FAULT;
                        paddr_q  <= '0;
                     end else begin
                        status_q <= XST_OK;
                        paddr_q  <= {lk_pfn, req_ofs};
                     end
                  end else begin
                     state_q <= FSM_PT_REQ;
                  end
               end
            end
            FSM_PT_REQ: begin
               if (mem_req_ready) state_q <= FSM_PT_WAIT;
            end
            FSM_PT_WAIT: begin
               if (mem_rsp_valid) begin
                  state_q <= FSM_RESP;
                  if (!pte_present) begin
                     status_q <= XST_PAGE_FAULT;
                     paddr_q  <= '0;
                  end else if (walk_deny) begin
                     status_q <= XST_PROT_FAULT;
                     paddr_q  <= '0;
                  end else begin
                     status_q <= XST_OK;
                     paddr_q  <= {pte_pfn, ofs_q};
                  end
               end
            end
            FSM_RESP: begin
               if (rsp_ready) state_q <= FSM_IDLE;
            end
            default: state_q <= FSM_IDLE;
         endcase
      end
   end

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)); // R9
   AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
   AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && lk_hit && !flush |=> rsp_valid && !mem_req_valid); // R2
   AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status != XST_OK |-> rsp_paddr == '0); // R5
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == XST_OK |-> rsp_paddr[OFS_W-1:0] == ofs_q); // R1
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_status != 2'b11); // R6

endmodule

// File: tb/test_paged_xlate_unit.sv
`timescale 1ns/1ps
module test_paged_xlate_unit;

   localparam logic [31:0] PT_BASE = 32'h0010_0000;
   localparam int NVEC = 10;
   // {vaddr, write, user, expect_walk}
   localparam logic [34:0] VEC [NVEC] = '{
      {32'h00007B00, 1'b0, 1'b0, 1'b1},
      {32'h00007A9C, 1'b1, 1'b1, 1'b0},
      {32'h0000F123, 1'b0, 1'b0, 1'b1},
      {32'h0000F456, 1'b0, 1'b0, 1'b1},
      {32'h00010004, 1'b1, 1'b0, 1'b1},
      {32'h00010004, 1'b0, 1'b0, 1'b0},
      {32'h00020FFF, 1'b0, 1'b1, 1'b1},
      {32'h00020FFF, 1'b1, 1'b0, 1'b0},
      {32'h0001F010, 1'b1, 1'b1, 1'b1},
      {32'h00030ABC, 1'b1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_ready = 1'b1;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_status;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;

   int checks = 0;
   int fails = 0;
   int mem_reads = 0;
   int mem_lat = 2;
   logic [31:0] last_addr = '0;

   always #2.5 clk = ~clk;

   paged_xlate_unit i_paged_xlate_unit (
      .clk (clk), .rst_n (rst_n), .flush (flush), .pt_base (PT_BASE),
      .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
      .req_write (req_write), .req_user (req_user),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
      .rsp_paddr (rsp_paddr), .rsp_status (rsp_status),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data)
   );

   // page-table model: page 7 -> frame 42; others frame = page + 0x100,
   // present unless low nibble is F, writable unless bit 4, user unless bit 5
   function automatic logic [31:0] pte_of(input logic [19:0] vpn);
      if (vpn == 20'd7) return 32'h0002A007;
      return {vpn + 20'h100, 9'b0, ~vpn[5], ~vpn[4], vpn[3:0] != 4'hF};
   endfunction

   task automatic exp_calc(input logic [31:0] va, input logic wr, usr,
                           output logic [31:0] pa, output logic [1:0] st);
      logic [31:0] p;
      p = pte_of(va[31:12]);
      if (!p[0]) begin st = 2'b01; pa = '0; end
      else if ((wr && !p[1]) || (usr && !p[2])) begin st = 2'b10; pa = '0; end
      else begin st = 2'b00; pa = {p[31:12], va[11:0]}; end
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            mem_reads++;
            last_addr = mem_req_addr;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (mem_lat) @(negedge clk);
            mem_rsp_data  = pte_of(20'((last_addr - PT_BASE) >> 2));
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   task automatic xlate(input logic [31:0] va, input logic wr, usr, input bit with_flush,
                        output logic [31:0] pa, output logic [1:0] st,
                        output bit walked, output int wc);
      int r0;
      r0 = mem_reads;
      @(negedge clk);
      req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1; flush = with_flush;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
      wc = 0;
      while (!rsp_valid) begin @(negedge clk); wc++; end
      pa = rsp_paddr; st = rsp_status; walked = (mem_reads != r0);
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic expect_hit(input logic [31:0] va, input string req);
      logic [31:0] pa; logic [1:0] st; bit w; int wc;
      xlate(va, 1'b0, 1'b0, 1'b0, pa, st, w, wc);
      chk(!w && wc == 0, req, "expected cache hit", 32'(w), 32'd0);
   endtask

   task automatic expect_walk(input logic [31:0] va, input bit with_flush, input string req);
      logic [31:0] pa; logic [1:0] st; bit w; int wc;
      xlate(va, 1'b0, 1'b0, with_flush, pa, st, w, wc);
      chk(w, req, "expected table walk", 32'(w), 32'd1);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1, "R9", "reset req_ready", 32'(req_ready), 32'd1);
      chk(rsp_valid === 1'b0, "R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
      chk(mem_req_valid === 1'b0, "R9", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);
      rst_n = 1'b1;

      // vector table walk: R1..R6
      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] va, pa, epa; logic wr, usr, ew; logic [1:0] st, est;
         bit w; int wc; string tag;
         {va, wr, usr, ew} = VEC[i];
         xlate(va, wr, usr, 1'b0, pa, st, w, wc);
         exp_calc(va, wr, usr, epa, est);
         tag = (est == 2'b01) ? "R5" : (est == 2'b10) ? "R6" : "R4";
         chk(st == est, tag, "status", 32'(st), 32'(est));
         chk(pa == epa, "R1", "paddr", pa, epa);
         chk(w == ew, ew ? "R3" : "R2", "walk", 32'(w), 32'(ew));
         if (ew) begin
            chk(last_addr == PT_BASE + {va[31:12], 2'b00}, "R3", "entry addr",
                last_addr, PT_BASE + {va[31:12], 2'b00});
            chk(wc == mem_lat + 2, "R3", "walk latency", 32'(wc), 32'(mem_lat + 2));
         end else begin
            chk(wc == 0, "R2", "hit latency", 32'(wc), 32'd0);
         end
         if (i == 0) chk(pa == 32'h0002AB00, "R1", "example page 7", pa, 32'h0002AB00);
         if (i == 1) chk(pa == 32'h0002AA9C, "R1", "offset kept", pa, 32'h0002AA9C);
      end

      // R8: flush empties the cache
      do_flush();
      expect_walk(32'h00007000, 1'b0, "R8");

      // R7: eight fills, then the ninth evicts the oldest
      for (int p = 0; p < 7; p++) expect_walk(32'h00040000 + (p << 12), 1'b0, "R7");
      expect_hit(32'h00007010, "R7");
      expect_walk(32'h00047000, 1'b0, "R7");
      expect_hit(32'h00041000, "R7");
      expect_walk(32'h00007020, 1'b0, "R7");

      // R8: request in the flush cycle is a miss, and the cache is emptied
      expect_walk(32'h00042000, 1'b1, "R8");
      expect_walk(32'h00043000, 1'b0, "R8");

      // R9: response held while rsp_ready is low
      begin
         logic [31:0] pa0;
         @(negedge clk);
         rsp_ready = 1'b0;
         req_vaddr = 32'h00043123; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         pa0 = rsp_paddr;
         for (int k = 0; k < 4; k++) begin
            chk(rsp_valid && !req_ready && rsp_paddr == pa0, "R9", "response held",
                rsp_paddr, pa0);
            @(negedge clk);
         end
         chk(pa0 == 32'h00143123, "R9", "held paddr", pa0, 32'h00143123);
         rsp_ready = 1'b1;
         @(negedge clk);
         chk(!rsp_valid && req_ready, "R9", "released", 32'(rsp_valid), 32'd0);
      end

      // R3: longer memory latency
      begin
         logic [31:0] pa; logic [1:0] st; bit w; int wc;
         mem_lat = 5;
         xlate(32'h00050ABC, 1'b0, 1'b1, 1'b0, pa, st, w, wc);
         chk(wc == 7, "R3", "slow walk latency", 32'(wc), 32'd7);
         chk(pa == 32'h00150ABC, "R3", "slow walk paddr", pa, 32'h00150ABC);
         chk(st == 2'b00, "R6", "user read allowed", 32'(st), 32'd0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule